// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block sits beside the processor core and decides what a stop instruction does. When the core pulses its stop strobe, the controller looks at the stop-enable bit, the power-down select bit and the two low-voltage-detector enables. From those bits it either requests an illegal-opcode reset, parks the chip in a light stop with every domain in standby, or drops into a deep stop in which only RAM stays powered. On entry to deep stop the controller captures the pad output values and keeps driving them until software writes an acknowledge. That hold lasts through the wake-up reset.

Deep stop ends only through the external reset pin, the interrupt pin or the periodic wake timer. While the chip is in deep stop, the interrupt pin is always read as active low. Leaving deep stop runs a power-on-style reset of fixed length, and a status flag then tells software that the wake came from deep stop. Software uses that flag to restore its saved port registers before it acknowledges. Light stop keeps register state, so any pending enabled interrupt, or any synchronized wake source, returns the chip straight to run with no reset.

Top module: `stop_mode_ctrl`

## Requirements
- R1: A stop strobe with stop_en = 0 keeps mode at RUN (encoding 0) and raises illegal_rst_req for exactly the one cycle after the strobe.
- R2: A stop strobe in RUN with stop_en = 1, pdn_sel = 1 and not (lvd_en = 1 and lvd_stop_en = 1) moves mode to DEEP (encoding 2) on the strobe's clock edge.
- R3: A stop strobe with stop_en = 1 enters LIGHT (encoding 1) when lvd_en and lvd_stop_en are both 1, whatever pdn_sel is. It also enters LIGHT when pdn_sel = 0.
- R4: On deep-stop entry, pad_out takes the pad_live value sampled at the strobe edge and pin_hold rises. Both stay unchanged through deep stop and the wake reset. One cycle after ack_wr = 1 in RUN, pin_hold is 0 and pad_out follows pad_live again.
- R5: In RUN the power outputs are dom_pwr_en = 1, core_clk_en = 1, reg_standby = 0 and adc_standby = 0. In LIGHT they are 1, 0, 1, 1. In DEEP they are 0, 0, 1, 1.
- R6: DEEP is left only on rst_pin_n low, irq_pin low or timer_wake high. int_pending is ignored in DEEP, and so is a high irq_pin configured active high.
- R7: Leaving DEEP enters WAKE (encoding 3) for POR_CYCLES cycles with por_rst_req = 1, then RUN. After that, pin_hold stays 1 and deep_wake_flag stays 1 until ack_wr = 1 in RUN.
- R8: LIGHT returns to RUN with no por_rst_req. It does so on the next edge when int_pending = 1, or when a synchronized wake source is active, with irq_pin read at its configured polarity (irq_pol_high).
- R9: rst_pin_n, irq_pin and timer_wake each pass through two flops, so a raw change alters mode on the third rising edge after it.
- R10: A stop strobe with stop_en = 1 leaves mode at RUN if a wake is active in the same cycle (int_pending, or a synchronized source).
- R11: After reset, mode = RUN and pin_hold, deep_wake_flag, illegal_rst_req and por_rst_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| stop_req | input | 1 | One-cycle strobe: core executed a stop instruction |
| stop_en | input | 1 | Stop instruction permitted |
| pdn_sel | input | 1 | Select deep (partial power-down) stop |
| lvd_en | input | 1 | Low-voltage detector enabled |
| lvd_stop_en | input | 1 | Low-voltage detector kept running in stop |
| ack_wr | input | 1 | Software writes 1 to release the pin hold |
| int_pending | input | 1 | An enabled interrupt is pending (core clock domain) |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| irq_pin | input | 1 | External interrupt pin, asynchronous |
| irq_pol_high | input | 1 | Configured interrupt polarity, 1 = active high |
| timer_wake | input | 1 | Periodic wake timer request, asynchronous |
| pad_live | input | NPINS | Pad output values from the port logic |
| pad_out | output | NPINS | Pad output values delivered to the pads |
| mode | output | 2 | 0 RUN, 1 LIGHT, 2 DEEP, 3 WAKE |
| dom_pwr_en | output | 1 | Regulator-powered domains switched on |
| core_clk_en | output | 1 | Core and peripheral clocks running |
| reg_standby | output | 1 | Regulator in standby |
| adc_standby | output | 1 | ADC in standby |
| pin_hold | output | 1 | Pad values held |
| illegal_rst_req | output | 1 | Illegal-opcode reset request pulse |
| por_rst_req | output | 1 | Power-on-style reset request during deep-stop wake |
| deep_wake_flag | output | 1 | Last reset was a wake from deep stop |

## Verification
Most of the state is visible at the ports. If the mode register is wrong, mode, the four power outputs and the reset lines all show it from the very next clock edge after the strobe or wake. A broken hold latch shows as pad_out following pad_live one cycle after the pads change. A fault in the synchronizer depth or the wake filtering shows up as a one-edge early or late change of mode, or as a wake that should not happen. The bench therefore samples mode at the second and third edges after each raw wake edge.

// File: rtl/stop_mode_pkg.sv
// Package: shared mode encoding for the stop mode controller.
// Assumes: mode values are also exported on the top-level mode port.
package stop_mode_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_LIGHT = 2'd1,
        MODE_DEEP  = 2'd2,
        MODE_WAKE  = 2'd3
    } pm_mode_e;

    // bit positions inside the synchronized wake vector
    localparam int WK_RST   = 0;
    localparam int WK_IRQ   = 1;
    localparam int WK_TIMER = 2;
    localparam int WK_W     = 3;

endpackage

// File: rtl/wake_sync.sv
// Module: wake_sync
// Two-flop synchronizer per bit for the asynchronous wake inputs.
// Assumes: each bit is an independent level; RST_VAL gives its idle level.
module wake_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] ff;
        // shift the raw level through two flops
        always_ff @(posedge clk) begin
            if (!rst_n) ff <= {2{RST_VAL[i]}};
            else        ff <= {ff[0], d[i]};
        end
        assign q[i] = ff[1];
    end

endmodule

// File: rtl/stop_decide.sv
// Module: stop_decide
// Maps the control bits to the stop target chosen for a stop strobe.
// Assumes: purely combinational; the caller qualifies with the strobe.
module stop_decide
    import stop_mode_pkg::*;
(
    input  logic     stop_en,
    input  logic     pdn_sel,
    input  logic     lvd_en,
    input  logic     lvd_stop_en,
    output pm_mode_e target,
    output logic     illegal
);

    logic lvd_in_stop;
    assign lvd_in_stop = lvd_en & lvd_stop_en;

    // priority: disabled stop, then detector forcing light, then select bit
    always_comb begin
        illegal = !stop_en;
        if (!stop_en)         target = MODE_RUN;
        else if (lvd_in_stop) target = MODE_LIGHT;
        else if (pdn_sel)     target = MODE_DEEP;
        else                  target = MODE_LIGHT;
    end

endmodule

// File: rtl/stop_fsm.sv
// Module: stop_fsm
// Mode state machine: run, light stop, deep stop and the wake reset window.
// Assumes: stop_req is a one-cycle strobe; wake inputs already synchronized.
module stop_fsm
    import stop_mode_pkg::*;
#(
    parameter int POR_CYCLES = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stop_req,
    input  pm_mode_e target,
    input  logic     illegal,
    input  logic     light_wake,
    input  logic     deep_wake,
    input  logic     ack_wr,
    output pm_mode_e mode_q,
    output logic     deep_enter,
    output logic     illegal_q,
    output logic     por_req,
    output logic     wake_flag_q
);

    localparam int CNT_W = $clog2(POR_CYCLES + 1);

    pm_mode_e   mode_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state selection
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN:   if (stop_req && !illegal && !light_wake) mode_d = target;
            MODE_LIGHT: if (light_wake) mode_d = MODE_RUN;
            MODE_DEEP:  if (deep_wake)  mode_d = MODE_WAKE;
            MODE_WAKE:  if (cnt_q == '0) mode_d = MODE_RUN;
            default:    mode_d = MODE_RUN;
        endcase
    end

    assign deep_enter = (mode_q == MODE_RUN) && (mode_d == MODE_DEEP);
    assign por_req    = (mode_q == MODE_WAKE);

    // mode register and wake-reset length counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_d;
            if (mode_q == MODE_DEEP && mode_d == MODE_WAKE)
                cnt_q <= CNT_W'(POR_CYCLES - 1);
            else if (mode_q == MODE_WAKE && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // illegal-opcode reset pulse, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= (mode_q == MODE_RUN) && stop_req && illegal;
    end

    // deep-wake status flag: set on wake, cleared by acknowledge in run
    always_ff @(posedge clk) begin
        if (!rst_n)                                   wake_flag_q <= 1'b0;
        else if (mode_q == MODE_DEEP && deep_wake)    wake_flag_q <= 1'b1;
        else if (mode_q == MODE_RUN && ack_wr)        wake_flag_q <= 1'b0;
    end

    AST_DEEP_EXIT_TO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == MODE_DEEP && mode_q != MODE_DEEP) |-> mode_q == MODE_WAKE); // R6
    AST_LIGHT_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == MODE_LIGHT && mode_q != MODE_LIGHT) |-> mode_q == MODE_RUN); // R8
    AST_ILLEGAL_STAYS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> mode_q == MODE_RUN); // R1
    AST_WAKE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag_q) |-> mode_q == MODE_WAKE); // R7

endmodule

// File: rtl/io_hold.sv
// Module: io_hold
// Captures pad values on deep-stop entry and drives them until released.
// Assumes: capture and release never arrive in the same cycle.
module io_hold #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             release_req,
    input  logic [NPINS-1:0] pad_live,
    output logic [NPINS-1:0] pad_out,
    output logic             hold_q
);

    logic [NPINS-1:0] lat_q;

    // hold flag and latched pad image
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            lat_q  <= '0;
        end else if (capture) begin
            hold_q <= 1'b1;
            lat_q  <= pad_live;
        end else if (release_req) begin
            hold_q <= 1'b0;
        end
    end

    assign pad_out = hold_q ? lat_q : pad_live;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && $past(hold_q)) |-> $stable(pad_out)); // R4

endmodule

// File: rtl/stop_mode_ctrl.sv
// Module: stop_mode_ctrl (top)
// Stop-mode controller: decides the stop target, runs the mode machine,
// holds the pads across deep stop and decodes the power controls.
// Assumes: rst_n is the true power-on reset of the always-on domain.
module stop_mode_ctrl
    import stop_mode_pkg::*;
#(
    parameter int NPINS      = 8,
    parameter int POR_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic             stop_en,
    input  logic             pdn_sel,
    input  logic             lvd_en,
    input  logic             lvd_stop_en,
    input  logic             ack_wr,
    input  logic             int_pending,
    input  logic             rst_pin_n,
    input  logic             irq_pin,
    input  logic             irq_pol_high,
    input  logic             timer_wake,
    input  logic [NPINS-1:0] pad_live,
    output logic [NPINS-1:0] pad_out,
    output logic [1:0]       mode,
    output logic             dom_pwr_en,
    output logic             core_clk_en,
    output logic             reg_standby,
    output logic             adc_standby,
    output logic             pin_hold,
    output logic             illegal_rst_req,
    output logic             por_rst_req,
    output logic             deep_wake_flag
);

    localparam logic [WK_W-1:0] WK_IDLE = WK_W'(3'b011);

    logic [WK_W-1:0] wk_raw, wk_s;
    logic            rst_act, irq_low, irq_cfg_act, tmr_act;
    logic            light_wake, deep_wake;
    pm_mode_e        target, mode_q;
    logic            illegal, deep_enter;

    assign wk_raw[WK_RST]   = rst_pin_n;
    assign wk_raw[WK_IRQ]   = irq_pin;
    assign wk_raw[WK_TIMER] = timer_wake;

    wake_sync #(.W(WK_W), .RST_VAL(WK_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(wk_raw), .q(wk_s)
    );

    // wake qualification: deep stop forces active-low interrupt reading
    always_comb begin
        rst_act     = !wk_s[WK_RST];
        irq_low     = !wk_s[WK_IRQ];
        irq_cfg_act = irq_pol_high ? wk_s[WK_IRQ] : !wk_s[WK_IRQ];
        tmr_act     = wk_s[WK_TIMER];
        deep_wake   = rst_act | irq_low | tmr_act;
        light_wake  = rst_act | irq_cfg_act | tmr_act | int_pending;
    end

    stop_decide u_decide (
        .stop_en(stop_en), .pdn_sel(pdn_sel), .lvd_en(lvd_en),
        .lvd_stop_en(lvd_stop_en), .target(target), .illegal(illegal)
    );

    stop_fsm #(.POR_CYCLES(POR_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .target(target),
        .illegal(illegal), .light_wake(light_wake), .deep_wake(deep_wake),
        .ack_wr(ack_wr), .mode_q(mode_q), .deep_enter(deep_enter),
        .illegal_q(illegal_rst_req), .por_req(por_rst_req),
        .wake_flag_q(deep_wake_flag)
    );

    io_hold #(.NPINS(NPINS)) u_hold (
        .clk(clk), .rst_n(rst_n), .capture(deep_enter),
        .release_req(ack_wr && (mode_q == MODE_RUN)),
        .pad_live(pad_live), .pad_out(pad_out), .hold_q(pin_hold)
    );

    // power-control decode from the current mode
    always_comb begin
        mode = mode_q;
        unique case (mode_q)
            MODE_LIGHT: {dom_pwr_en, core_clk_en, reg_standby, adc_standby} = 4'b1011;
            MODE_DEEP:  {dom_pwr_en, core_clk_en, reg_standby, adc_standby} = 4'b0011;
            MODE_WAKE:  {dom_pwr_en, core_clk_en, reg_standby, adc_standby} = 4'b1000;
            default:    {dom_pwr_en, core_clk_en, reg_standby, adc_standby} = 4'b1100;
        endcase
    end

    AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_rst_req |-> $past(stop_req && !stop_en)); // R1
    AST_DEEP_ENTRY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DEEP && $past(mode_q) == MODE_RUN)
        |-> $past(stop_en && pdn_sel && !(lvd_en && lvd_stop_en))); // R2
    AST_DEEP_PWR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DEEP) |-> (!dom_pwr_en && reg_standby && adc_standby)); // R5
    AST_WAKE_BLOCKS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == MODE_RUN && $past(stop_req) && $past(int_pending))
        |-> mode_q == MODE_RUN); // R10
    AST_HOLD_IN_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DEEP) |-> pin_hold); // R4

endmodule

// File: tb/stop_mode_ctrl_bench.sv
module stop_mode_ctrl_bench;

    localparam int NPINS = 8;
    localparam int PORC  = 4;

    logic clk = 1'b0;
    logic rst_n, stop_req, stop_en, pdn_sel, lvd_en, lvd_stop_en, ack_wr;
    logic int_pending, rst_pin_n, irq_pin, irq_pol_high, timer_wake;
    logic [NPINS-1:0] pad_live, pad_out, cap;
    logic [1:0] mode;
    logic dom_pwr_en, core_clk_en, reg_standby, adc_standby;
    logic pin_hold, illegal_rst_req, por_rst_req, deep_wake_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    stop_mode_ctrl #(.NPINS(NPINS), .POR_CYCLES(PORC)) u_stop_mode_ctrl (.*);

    function automatic logic [1:0] exp_mode(logic se, logic pd, logic le, logic ls);
        if (!se)            return 2'd0;
        else if (le && ls)  return 2'd1;
        else if (pd)        return 2'd2;
        else                return 2'd1;
    endfunction

    function automatic logic [3:0] exp_pwr(logic [1:0] m);
        case (m)
            2'd1:    return 4'b1011;
            2'd2:    return 4'b0011;
            2'd3:    return 4'b1000;
            default: return 4'b1100;
        endcase
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(logic ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_mode(logic [1:0] m, string req);
        chk(mode == m, req, 32'(mode), 32'(m));
        chk({dom_pwr_en, core_clk_en, reg_standby, adc_standby} == exp_pwr(m), "R5",
            32'({dom_pwr_en, core_clk_en, reg_standby, adc_standby}), 32'(exp_pwr(m)));
    endtask

    // issue a stop strobe with the given bits; returns after the entry edge
    task automatic do_stop(logic se, logic pd, logic le, logic ls, logic [NPINS-1:0] pins);
        stop_en = se; pdn_sel = pd; lvd_en = le; lvd_stop_en = ls;
        pad_live = pins; stop_req = 1'b1;
        tick(1);
        stop_req = 1'b0;
    endtask

    // wake deep stop from source 0 reset pin, 1 irq pin, 2 timer
    task automatic deep_wake(int src);
        int_pending = 1'b1;                       // R6: ignored in deep
        tick(4);
        chk_mode(2'd2, "R6");
        int_pending = 1'b0;
        irq_pol_high = 1'b1;                      // R6: configured high, pin high, no wake
        tick(4);
        chk_mode(2'd2, "R6");
        irq_pol_high = 1'b0;
        pad_live = ~cap;
        tick(1);
        chk(pad_out == cap, "R4", 32'(pad_out), 32'(cap));
        case (src)
            0:       rst_pin_n  = 1'b0;
            1:       irq_pin    = 1'b0;
            default: timer_wake = 1'b1;
        endcase
        tick(2);
        chk_mode(2'd2, "R9");
        tick(1);
        chk_mode(2'd3, "R7");
        chk(por_rst_req == 1'b1, "R7", 32'(por_rst_req), 1);
        rst_pin_n = 1'b1; irq_pin = 1'b1; timer_wake = 1'b0;
        tick(PORC - 1);
        chk(mode == 2'd3, "R7", 32'(mode), 3);
        tick(1);
        chk_mode(2'd0, "R7");
        chk(por_rst_req == 1'b0, "R7", 32'(por_rst_req), 0);
        chk(pin_hold && deep_wake_flag, "R7", 32'({pin_hold, deep_wake_flag}), 3);
        chk(pad_out == cap, "R4", 32'(pad_out), 32'(cap));
        ack_wr = 1'b1;
        tick(1);
        ack_wr = 1'b0;
        chk(!pin_hold && !deep_wake_flag, "R4", 32'({pin_hold, deep_wake_flag}), 0);
        chk(pad_out == pad_live, "R4", 32'(pad_out), 32'(pad_live));
        tick(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; stop_req = 0; stop_en = 0; pdn_sel = 0; lvd_en = 0; lvd_stop_en = 0;
        ack_wr = 0; int_pending = 0; rst_pin_n = 1; irq_pin = 1; irq_pol_high = 0;
        timer_wake = 0; pad_live = '0;
        tick(3);
        rst_n = 1;
        tick(3);
        // R11 reset state
        chk_mode(2'd0, "R11");
        chk({pin_hold, deep_wake_flag, illegal_rst_req, por_rst_req} == 4'b0, "R11",
            32'({pin_hold, deep_wake_flag, illegal_rst_req, por_rst_req}), 0);

        // R1 illegal stop
        do_stop(0, 1, 0, 0, 8'h5A);
        chk(illegal_rst_req == 1'b1, "R1", 32'(illegal_rst_req), 1);
        chk_mode(2'd0, "R1");
        tick(1);
        chk(illegal_rst_req == 1'b0, "R1", 32'(illegal_rst_req), 0);

        // R10 wake in same cycle as strobe
        int_pending = 1'b1;
        do_stop(1, 1, 0, 0, 8'h11);
        int_pending = 1'b0;
        chk_mode(2'd0, "R10");
        chk(pin_hold == 1'b0, "R10", 32'(pin_hold), 0);
        timer_wake = 1'b1;
        tick(2);
        do_stop(1, 0, 0, 0, 8'h22);
        chk_mode(2'd0, "R10");
        timer_wake = 1'b0;
        tick(3);

        // R3 detector forces light even with deep selected
        do_stop(1, 1, 1, 1, 8'h33);
        chk_mode(2'd1, "R3");
        chk(pin_hold == 1'b0, "R3", 32'(pin_hold), 0);
        irq_pol_high = 1'b1;                      // R8: configured polarity wakes light
        tick(1);
        chk_mode(2'd0, "R8");
        chk(por_rst_req == 1'b0, "R8", 32'(por_rst_req), 0);
        irq_pol_high = 1'b0;
        tick(3);

        // R2 deep entry, irq wake
        cap = 8'hC3;
        do_stop(1, 1, 1, 0, cap);
        chk_mode(2'd2, "R2");
        chk(pin_hold == 1'b1, "R4", 32'(pin_hold), 1);
        deep_wake(1);

        // randomized sequences
        for (int it = 0; it < 60; it++) begin
            logic se, pd, le, ls;
            logic [1:0] em;
            se = ($urandom % 4) != 0;
            pd = 1'($urandom); le = 1'($urandom); ls = 1'($urandom);
            cap = NPINS'($urandom);
            em = exp_mode(se, pd, le, ls);
            do_stop(se, pd, le, ls, cap);
            if (!se) begin
                chk(illegal_rst_req == 1'b1, "R1", 32'(illegal_rst_req), 1);
                chk_mode(2'd0, "R1");
                tick(1);
            end else if (em == 2'd2) begin
                chk_mode(2'd2, "R2");
                deep_wake(int'($urandom % 3));
            end else begin
                chk_mode(2'd1, "R3");
                chk(pad_out == pad_live, "R3", 32'(pad_out), 32'(pad_live));
                if ($urandom % 2 == 0) begin
                    int_pending = 1'b1;
                    tick(1);
                    int_pending = 1'b0;
                    chk_mode(2'd0, "R8");
                end else begin
                    timer_wake = 1'b1;
                    tick(2);
                    chk_mode(2'd1, "R9");
                    tick(1);
                    chk_mode(2'd0, "R8");
                    timer_wake = 1'b0;
                end
                chk(por_rst_req == 1'b0, "R8", 32'(por_rst_req), 0);
                tick(3);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule